// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a 32 by 32 pointer image on top of a raster stream of RGB pixels. The image lives in a small on-block memory as a 2-bit code per pixel, four codes to a byte. Software fills it one byte at a time through a single data address of a byte-wide register port. For every incoming valid pixel the block works out the raster position, decides whether that position lies inside the pointer window, and emits the pixel either unchanged, colour-inverted, or replaced by one of three programmed colours.

The window is anchored by a programmed pointer position less a hot-spot offset, so the hot-spot pixel of the image lands exactly on the pointer position. Position, hot spot, enable and mode are held in shadow registers and copied into the working set on the first pixel of a frame, so a move never tears a frame. Every pixel leaves the block exactly two cycles after it enters, with its line-start and frame-start markers.

Top module: `cursor_overlay`

## Requirements
- R1: Each output (valid, line start, frame start, pixel) shows the corresponding input exactly two clock cycles later; markers are passed only on valid pixels. While reset is held, `out_valid`, `out_sol` and `out_sof` are 0.
- R2: When control bit 0 (enable, address 0x06) is 0 in the working set, every output pixel equals its input pixel.
- R3: A write to address 0x07 stores the data byte at the bitmap pointer and then advances the pointer by one, wrapping from 255 to 0; a write of any value to address 0x08 rewinds the pointer to 0. Reset sets the pointer to 0.
- R4: Image pixel (column c, row r) is held in byte r*8 + c/4, in bits [2k+1:2k] with k = c mod 4.
- R5: Code 00 leaves the pixel unchanged, code 01 replaces it with colour A and code 10 with colour B. Colour A is written at 0x10, 0x11, 0x12 (red, green, blue bytes), colour B at 0x14..0x16; pixels are packed red in [23:16], green in [15:8], blue in [7:0].
- R6: Code 11 inverts every bit of the pixel when control bit 1 is 0, and replaces it with the auxiliary colour (0x18..0x1A) when control bit 1 is 1.
- R7: The window origin is (position x minus hot-spot x, position y minus hot-spot y); the pixel at the pointer position shows image entry (hot-spot x, hot-spot y). Position x is at 0x00 (low byte) and 0x01 (upper bits), position y at 0x02 and 0x03, hot-spot x at 0x04, hot-spot y at 0x05 (5 bits each).
- R8: Parts of the window left of column 0, above row 0, or beyond the last pixel or line are dropped; the image never wraps to the opposite edge.
- R9: Position, hot spot and control writes take effect from the next valid frame-start pixel on, including that pixel itself; colour writes take effect at once.
- R10: A valid frame-start pixel is raster (0,0), a valid line-start pixel opens the next row at column 0, every other valid pixel is one column right of the previous valid pixel, and cycles with valid low move nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_sol | input | 1 | First pixel of a line |
| pix_sof | input | 1 | First pixel of a frame |
| pix_rgb | input | 24 | Input pixel, red in the top byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Line start of the output pixel |
| out_sof | output | 1 | Frame start of the output pixel |
| out_rgb | output | 24 | Output pixel |

## Verification
The hardest case to reach is a pointer update that lands in the middle of a frame while the window is half clipped at the right and bottom edges, because the shadow copy must stay invisible until the following frame-start pixel. The stimulus rewrites the position between two rows of a frame whose window hangs off the lower right corner, then runs a further frame where the new origin must appear. Other frames push the origin to negative coordinates through a large hot spot, sprinkle idle cycles between pixels, and use an image that includes a hand-placed byte holding all four codes in column order.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int CFG_AW = 5;

  localparam logic [CFG_AW-1:0] A_POS_X_LO  = 5'h00;
  localparam logic [CFG_AW-1:0] A_POS_X_HI  = 5'h01;
  localparam logic [CFG_AW-1:0] A_POS_Y_LO  = 5'h02;
  localparam logic [CFG_AW-1:0] A_POS_Y_HI  = 5'h03;
  localparam logic [CFG_AW-1:0] A_HOT_X     = 5'h04;
  localparam logic [CFG_AW-1:0] A_HOT_Y     = 5'h05;
  localparam logic [CFG_AW-1:0] A_CTRL      = 5'h06;
  localparam logic [CFG_AW-1:0] A_BM_DATA   = 5'h07;
  localparam logic [CFG_AW-1:0] A_BM_REWIND = 5'h08;
  localparam int                PAL_BASE    = 16;
  localparam int                PAL_STRIDE  = 4;
  localparam int                PAL_COUNT   = 3;

  typedef enum logic [1:0] {
    CODE_CLEAR   = 2'b00,
    CODE_COL_A   = 2'b01,
    CODE_COL_B   = 2'b10,
    CODE_SPECIAL = 2'b11
  } cur_code_e;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs import cursor_pkg::*; #(
  parameter int POS_W = 11,
  parameter int HOT_W = 5,
  parameter int CH_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [7:0]          cfg_wdata,
  input  logic                frame_load,
  output logic [POS_W-1:0]    view_pos_x,
  output logic [POS_W-1:0]    view_pos_y,
  output logic [HOT_W-1:0]    view_hot_x,
  output logic [HOT_W-1:0]    view_hot_y,
  output logic                view_en,
  output logic                view_mode,
  output logic [3*CH_W-1:0]   col_a,
  output logic [3*CH_W-1:0]   col_b,
  output logic [3*CH_W-1:0]   col_aux,
  output logic                bm_push,
  output logic                bm_rewind,
  output logic [7:0]          bm_byte
);

  localparam int RGB_W = 3 * CH_W;
  localparam int HI_W  = POS_W - 8;

  logic [POS_W-1:0] sh_pos_x, sh_pos_x_nxt, act_pos_x;
  logic [POS_W-1:0] sh_pos_y, sh_pos_y_nxt, act_pos_y;
  logic [HOT_W-1:0] sh_hot_x, sh_hot_x_nxt, act_hot_x;
  logic [HOT_W-1:0] sh_hot_y, sh_hot_y_nxt, act_hot_y;
  logic             sh_en, sh_en_nxt, act_en;
  logic             sh_mode, sh_mode_nxt, act_mode;
  logic [RGB_W-1:0] pal_q   [PAL_COUNT];
  logic [RGB_W-1:0] pal_nxt [PAL_COUNT];

  // next state of shadow registers and palette
  always_comb begin
    sh_pos_x_nxt = sh_pos_x;
    sh_pos_y_nxt = sh_pos_y;
    sh_hot_x_nxt = sh_hot_x;
    sh_hot_y_nxt = sh_hot_y;
    sh_en_nxt    = sh_en;
    sh_mode_nxt  = sh_mode;
    if (cfg_we) begin
      case (cfg_addr)
        A_POS_X_LO: sh_pos_x_nxt[7:0]       = cfg_wdata;
        A_POS_X_HI: sh_pos_x_nxt[POS_W-1:8] = cfg_wdata[HI_W-1:0];
        A_POS_Y_LO: sh_pos_y_nxt[7:0]       = cfg_wdata;
        A_POS_Y_HI: sh_pos_y_nxt[POS_W-1:8] = cfg_wdata[HI_W-1:0];
        A_HOT_X:    sh_hot_x_nxt            = cfg_wdata[HOT_W-1:0];
        A_HOT_Y:    sh_hot_y_nxt            = cfg_wdata[HOT_W-1:0];
        A_CTRL: begin
          sh_en_nxt   = cfg_wdata[0];
          sh_mode_nxt = cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int e = 0; e < PAL_COUNT; e++) begin
      pal_nxt[e] = pal_q[e];
      for (int c = 0; c < 3; c++) begin
        if (cfg_we && (cfg_addr == CFG_AW'(PAL_BASE + PAL_STRIDE * e + c))) begin
          pal_nxt[e][RGB_W-1-c*CH_W -: CH_W] = cfg_wdata[CH_W-1:0];
        end
      end
    end
  end

  // shadow registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pos_x <= '0;
      sh_pos_y <= '0;
      sh_hot_x <= '0;
      sh_hot_y <= '0;
      sh_en    <= 1'b0;
      sh_mode  <= 1'b0;
      for (int e = 0; e < PAL_COUNT; e++) pal_q[e] <= '0;
    end else if (cfg_we) begin
      sh_pos_x <= sh_pos_x_nxt;
      sh_pos_y <= sh_pos_y_nxt;
      sh_hot_x <= sh_hot_x_nxt;
      sh_hot_y <= sh_hot_y_nxt;
      sh_en    <= sh_en_nxt;
      sh_mode  <= sh_mode_nxt;
      for (int e = 0; e < PAL_COUNT; e++) pal_q[e] <= pal_nxt[e];
    end
  end

  // working set, enabled by the frame-start pixel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pos_x <= '0;
      act_pos_y <= '0;
      act_hot_x <= '0;
      act_hot_y <= '0;
      act_en    <= 1'b0;
      act_mode  <= 1'b0;
    end else if (frame_load) begin
      act_pos_x <= sh_pos_x;
      act_pos_y <= sh_pos_y;
      act_hot_x <= sh_hot_x;
      act_hot_y <= sh_hot_y;
      act_en    <= sh_en;
      act_mode  <= sh_mode;
    end
  end

  // the frame-start pixel already sees the shadow values
  always_comb begin
    view_pos_x = frame_load ? sh_pos_x : act_pos_x;
    view_pos_y = frame_load ? sh_pos_y : act_pos_y;
    view_hot_x = frame_load ? sh_hot_x : act_hot_x;
    view_hot_y = frame_load ? sh_hot_y : act_hot_y;
    view_en    = frame_load ? sh_en    : act_en;
    view_mode  = frame_load ? sh_mode  : act_mode;
  end

  assign col_a     = pal_q[0];
  assign col_b     = pal_q[1];
  assign col_aux   = pal_q[2];
  assign bm_push   = cfg_we && (cfg_addr == A_BM_DATA);
  assign bm_rewind = cfg_we && (cfg_addr == A_BM_REWIND);
  assign bm_byte   = cfg_wdata;

  // R9: register writes between frame starts leave the working set alone
  p_shadow_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !frame_load) |=> ($stable(act_pos_x) && $stable(act_pos_y) &&
                                 $stable(act_hot_x) && $stable(act_hot_y) &&
                                 $stable(act_en) && $stable(act_mode)));

  // R9: a frame start adopts what the shadow held
  p_frame_adopt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (act_pos_x == $past(sh_pos_x)) && (act_en == $past(sh_en)));

endmodule

// File: rtl/cursor_bitmap.sv
module cursor_bitmap #(
  parameter int CUR_LOG2 = 5,
  parameter int AW       = 2 * CUR_LOG2 - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          rewind,
  input  logic [7:0]    wbyte,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);

  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr_q, ptr_nxt;
  logic [7:0]    rd_q;

  always_comb begin
    ptr_nxt = ptr_q;
    if (rewind)    ptr_nxt = '0;
    else if (push) ptr_nxt = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= '0;
    else if (push || rewind) ptr_q <= ptr_nxt;
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (push) mem[ptr_q] <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_byte = rd_q;

  // R3: each data write moves the pointer on by one, wrapping at the top
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rewind) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R3: a rewind write returns the pointer to the first byte
  p_ptr_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (ptr_q == '0));

endmodule

// File: rtl/cursor_locate.sv
module cursor_locate #(
  parameter int POS_W    = 11,
  parameter int HOT_W    = 5,
  parameter int CUR_LOG2 = 5,
  parameter int AW       = 2 * CUR_LOG2 - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sol,
  input  logic             pix_sof,
  input  logic [POS_W-1:0] pos_x,
  input  logic [POS_W-1:0] pos_y,
  input  logic [HOT_W-1:0] hot_x,
  input  logic [HOT_W-1:0] hot_y,
  input  logic             en,
  output logic             hit,
  output logic [AW-1:0]    bm_addr,
  output logic [1:0]       sub
);

  localparam int DW = POS_W + 2;

  logic [POS_W-1:0] x_q, y_q, cur_x, cur_y;
  logic [DW-1:0]    org_x, org_y, dx, dy;
  logic             in_x, in_y;

  // raster position of the pixel now at the input
  always_comb begin
    if (pix_sof) begin
      cur_x = '0;
      cur_y = '0;
    end else if (pix_sol) begin
      cur_x = '0;
      cur_y = y_q + 1'b1;
    end else begin
      cur_x = x_q + 1'b1;
      cur_y = y_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (pix_valid) begin
      x_q <= cur_x;
      y_q <= cur_y;
    end
  end

  // offsets from the window origin in two's complement, no wrap
  always_comb begin
    org_x = {2'b00, pos_x} - {{(DW-HOT_W){1'b0}}, hot_x};
    org_y = {2'b00, pos_y} - {{(DW-HOT_W){1'b0}}, hot_y};
    dx    = {2'b00, cur_x} - org_x;
    dy    = {2'b00, cur_y} - org_y;
    in_x  = (dx[DW-1:CUR_LOG2] == '0);
    in_y  = (dy[DW-1:CUR_LOG2] == '0);
    hit   = en && in_x && in_y;
  end

  assign bm_addr = {dy[CUR_LOG2-1:0], dx[CUR_LOG2-1:2]};
  assign sub     = dx[1:0];

  // R10: line start puts the column back to zero
  p_line_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_sol) |=> (x_q == '0));

  // R10: frame start puts the raster at the origin
  p_frame_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_sof) |=> (x_q == '0) && (y_q == '0));

  // R10: a line start inside a frame moves down one row
  p_row_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_sol && !pix_sof) |=> (y_q == $past(y_q) + 1'b1));

  // R10: idle cycles leave the raster where it was
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(x_q) && $stable(y_q)));

endmodule

// File: rtl/cursor_blend.sv
module cursor_blend import cursor_pkg::*; #(
  parameter int CH_W = 8
) (
  input  logic [3*CH_W-1:0] rgb_in,
  input  logic              hit,
  input  logic              mode,
  input  logic [7:0]        bm_byte,
  input  logic [1:0]        sub,
  input  logic [3*CH_W-1:0] col_a,
  input  logic [3*CH_W-1:0] col_b,
  input  logic [3*CH_W-1:0] col_aux,
  output logic [3*CH_W-1:0] rgb_out
);

  cur_code_e code;

  always_comb begin
    code = cur_code_e'(bm_byte[{sub, 1'b0} +: 2]);
    rgb_out = rgb_in;
    if (hit) begin
      case (code)
        CODE_COL_A:   rgb_out = col_a;
        CODE_COL_B:   rgb_out = col_b;
        CODE_SPECIAL: rgb_out = mode ? col_aux : ~rgb_in;
        default:      rgb_out = rgb_in;
      endcase
    end
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay import cursor_pkg::*; #(
  parameter int CH_W     = 8,
  parameter int POS_W    = 11,
  parameter int CUR_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_valid,
  input  logic                pix_sol,
  input  logic                pix_sof,
  input  logic [3*CH_W-1:0]   pix_rgb,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic                out_valid,
  output logic                out_sol,
  output logic                out_sof,
  output logic [3*CH_W-1:0]   out_rgb
);

  localparam int RGB_W = 3 * CH_W;
  localparam int HOT_W = CUR_LOG2;
  localparam int BM_AW = 2 * CUR_LOG2 - 2;

  logic             frame_load;
  logic [POS_W-1:0] view_pos_x, view_pos_y;
  logic [HOT_W-1:0] view_hot_x, view_hot_y;
  logic             view_en, view_mode;
  logic [RGB_W-1:0] col_a, col_b, col_aux;
  logic             bm_push, bm_rewind;
  logic [7:0]       bm_byte, rd_byte;
  logic             hit;
  logic [BM_AW-1:0] bm_addr;
  logic [1:0]       sub;

  logic             s1_valid, s1_sol, s1_sof, s1_hit, s1_mode;
  logic [1:0]       s1_sub;
  logic [RGB_W-1:0] s1_rgb;
  logic [RGB_W-1:0] blend_rgb;
  logic             o_valid_q, o_sol_q, o_sof_q;
  logic [RGB_W-1:0] o_rgb_q;

  assign frame_load = pix_valid && pix_sof;

  cursor_regs #(.POS_W(POS_W), .HOT_W(HOT_W), .CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .frame_load (frame_load),
    .view_pos_x (view_pos_x),
    .view_pos_y (view_pos_y),
    .view_hot_x (view_hot_x),
    .view_hot_y (view_hot_y),
    .view_en    (view_en),
    .view_mode  (view_mode),
    .col_a      (col_a),
    .col_b      (col_b),
    .col_aux    (col_aux),
    .bm_push    (bm_push),
    .bm_rewind  (bm_rewind),
    .bm_byte    (bm_byte)
  );

  cursor_locate #(.POS_W(POS_W), .HOT_W(HOT_W), .CUR_LOG2(CUR_LOG2), .AW(BM_AW)) u_locate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sol   (pix_sol),
    .pix_sof   (pix_sof),
    .pos_x     (view_pos_x),
    .pos_y     (view_pos_y),
    .hot_x     (view_hot_x),
    .hot_y     (view_hot_y),
    .en        (view_en),
    .hit       (hit),
    .bm_addr   (bm_addr),
    .sub       (sub)
  );

  cursor_bitmap #(.CUR_LOG2(CUR_LOG2), .AW(BM_AW)) u_bitmap (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (bm_push),
    .rewind  (bm_rewind),
    .wbyte   (bm_byte),
    .rd_en   (pix_valid && hit),
    .rd_addr (bm_addr),
    .rd_byte (rd_byte)
  );

  // stage 1: markers every cycle, payload on valid pixels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sol   <= 1'b0;
      s1_sof   <= 1'b0;
    end else begin
      s1_valid <= pix_valid;
      s1_sol   <= pix_valid && pix_sol;
      s1_sof   <= pix_valid && pix_sof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rgb  <= '0;
      s1_hit  <= 1'b0;
      s1_mode <= 1'b0;
      s1_sub  <= '0;
    end else if (pix_valid) begin
      s1_rgb  <= pix_rgb;
      s1_hit  <= hit;
      s1_mode <= view_mode;
      s1_sub  <= sub;
    end
  end

  cursor_blend #(.CH_W(CH_W)) u_blend (
    .rgb_in  (s1_rgb),
    .hit     (s1_hit),
    .mode    (s1_mode),
    .bm_byte (rd_byte),
    .sub     (s1_sub),
    .col_a   (col_a),
    .col_b   (col_b),
    .col_aux (col_aux),
    .rgb_out (blend_rgb)
  );

  // stage 2: output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid_q <= 1'b0;
      o_sol_q   <= 1'b0;
      o_sof_q   <= 1'b0;
    end else begin
      o_valid_q <= s1_valid;
      o_sol_q   <= s1_sol;
      o_sof_q   <= s1_sof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        o_rgb_q <= '0;
    else if (s1_valid) o_rgb_q <= blend_rgb;
  end

  assign out_valid = o_valid_q;
  assign out_sol   = o_sol_q;
  assign out_sof   = o_sof_q;
  assign out_rgb   = o_rgb_q;

  // checking aids: cycles since reset, and the code under the stage-1 pixel
  logic [1:0] live_q;
  logic [1:0] chk_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_q <= '0;
    else if (live_q != 2'd2) live_q <= live_q + 1'b1;
  end

  assign chk_code = rd_byte[{s1_sub, 1'b0} +: 2];

  // R1: the stream comes out two cycles after it went in
  p_two_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == 2'd2) |-> (out_valid == $past(pix_valid, 2)) &&
                         (out_sof == $past(pix_valid && pix_sof, 2)) &&
                         (out_sol == $past(pix_valid && pix_sol, 2)));

  // R2, R5: a pixel outside the window or on a clear code passes untouched
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s1_valid && (!s1_hit || chk_code == 2'b00)) |-> (out_rgb == $past(s1_rgb)));

  // R5: code 10 paints colour B
  p_colour_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s1_valid && s1_hit && chk_code == 2'b10) |-> (out_rgb == $past(col_b)));

  // R6: code 11 without the mode bit inverts the pixel
  p_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s1_valid && s1_hit && chk_code == 2'b11 && !s1_mode) |-> (out_rgb == ~$past(s1_rgb)));

endmodule

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;
  import cursor_pkg::*;

  localparam int FW = 48;
  localparam int FH = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_valid, pix_sol, pix_sof;
  logic [23:0] pix_rgb;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        out_valid, out_sol, out_sof;
  logic [23:0] out_rgb;

  always #2.5 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_sof(pix_sof), .pix_rgb(pix_rgb),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_rgb(out_rgb)
  );

  int    checks = 0;
  int    errs   = 0;
  string cur_req = "R1";

  // model state
  logic [7:0]  bm [256];
  int          bm_ptr = 0;
  logic [23:0] pal [3];
  int s_px = 0, s_py = 0, s_hx = 0, s_hy = 0, s_en = 0, s_mode = 0;
  int m_px = 0, m_py = 0, m_hx = 0, m_hy = 0, m_en = 0, m_mode = 0;

  // staged stimulus
  logic        st_valid = 0, st_sol = 0, st_sof = 0, st_we = 0;
  logic [23:0] st_rgb = '0;
  logic [4:0]  st_addr = '0;
  logic [7:0]  st_wdata = '0;
  int          st_x = 0, st_y = 0;

  // two-deep expectation pipe
  logic        e0_v = 0, e0_sol = 0, e0_sof = 0, e1_v = 0, e1_sol = 0, e1_sof = 0;
  logic [23:0] e0_rgb = '0, e1_rgb = '0;

  function automatic logic [23:0] pix_of(int x, int y);
    return {8'(x * 5 + y), 8'(y * 3 + 1), 8'(x ^ (y * 7))};
  endfunction

  function automatic logic [23:0] model_out(int x, int y, logic [23:0] rgb);
    int dx, dy, code;
    dx = x - (m_px - m_hx);
    dy = y - (m_py - m_hy);
    if (m_en == 0 || dx < 0 || dx > 31 || dy < 0 || dy > 31) return rgb;
    code = (int'(bm[dy * 8 + dx / 4]) >> (2 * (dx % 4))) & 3;
    case (code)
      1: return pal[0];
      2: return pal[1];
      3: return (m_mode != 0) ? pal[2] : ~rgb;
      default: return rgb;
    endcase
  endfunction

  task automatic model_write(logic [4:0] a, logic [7:0] d);
    int ia;
    ia = int'(a);
    case (a)
      A_POS_X_LO: s_px = (s_px & 32'h700) | int'(d);
      A_POS_X_HI: s_px = (s_px & 32'hFF) | (int'(d[2:0]) << 8);
      A_POS_Y_LO: s_py = (s_py & 32'h700) | int'(d);
      A_POS_Y_HI: s_py = (s_py & 32'hFF) | (int'(d[2:0]) << 8);
      A_HOT_X:    s_hx = int'(d[4:0]);
      A_HOT_Y:    s_hy = int'(d[4:0]);
      A_CTRL: begin s_en = int'(d[0]); s_mode = int'(d[1]); end
      A_BM_DATA: begin bm[bm_ptr] = d; bm_ptr = (bm_ptr + 1) % 256; end
      A_BM_REWIND: bm_ptr = 0;
      default:
        if (ia >= 16 && ((ia - 16) % 4) < 3 && ((ia - 16) / 4) < 3)
          pal[(ia - 16) / 4][23 - 8 * ((ia - 16) % 4) -: 8] = d;
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
    checks++;
    if (out_valid !== e1_v || out_sol !== e1_sol || out_sof !== e1_sof ||
        (e1_v && out_rgb !== e1_rgb)) begin
      errs++;
      $display("FAIL %s: v/sol/sof/rgb actual %b%b%b %h expected %b%b%b %h", cur_req,
               out_valid, out_sol, out_sof, out_rgb, e1_v, e1_sol, e1_sof, e1_rgb);
    end
    e1_v = e0_v; e1_sol = e0_sol; e1_sof = e0_sof; e1_rgb = e0_rgb;
    pix_valid = st_valid; pix_sol = st_sol; pix_sof = st_sof; pix_rgb = st_rgb;
    cfg_we = st_we; cfg_addr = st_addr; cfg_wdata = st_wdata;
    if (st_valid && st_sof) begin
      m_px = s_px; m_py = s_py; m_hx = s_hx; m_hy = s_hy; m_en = s_en; m_mode = s_mode;
    end
    e0_v   = st_valid;
    e0_sol = st_valid && st_sol;
    e0_sof = st_valid && st_sof;
    e0_rgb = st_valid ? model_out(st_x, st_y, st_rgb) : '0;
    if (st_we) model_write(st_addr, st_wdata);
  endtask

  task automatic idle_tick();
    st_valid = 0; st_we = 0; st_sol = 1; st_sof = 0; st_rgb = 24'hA5A5A5;
    tick();
  endtask

  task automatic write_reg(logic [4:0] a, logic [7:0] d);
    st_valid = 0; st_sol = 0; st_sof = 0;
    st_we = 1; st_addr = a; st_wdata = d;
    tick();
    st_we = 0;
  endtask

  task automatic set_cursor(int px, int py, int hx, int hy, int ctrl);
    write_reg(A_POS_X_LO, 8'(px));
    write_reg(A_POS_X_HI, 8'(px >> 8));
    write_reg(A_POS_Y_LO, 8'(py));
    write_reg(A_POS_Y_HI, 8'(py >> 8));
    write_reg(A_HOT_X, 8'(hx));
    write_reg(A_HOT_Y, 8'(hy));
    write_reg(A_CTRL, 8'(ctrl));
  endtask

  task automatic run_frame(int gap, int mid_row, int mid_px);
    for (int y = 0; y < FH; y++) begin
      if (y == mid_row) begin
        write_reg(A_POS_X_LO, 8'(mid_px));
        write_reg(A_POS_X_HI, 8'(mid_px >> 8));
      end
      for (int x = 0; x < FW; x++) begin
        st_we = 0; st_valid = 1; st_sol = (x == 0); st_sof = (x == 0 && y == 0);
        st_rgb = pix_of(x, y); st_x = x; st_y = y;
        tick();
        if (gap > 0 && ((x + y) % gap) == 0) idle_tick();
      end
    end
    idle_tick();
    idle_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) pal[i] = '0;
    rst_n = 0; pix_valid = 1; pix_sol = 1; pix_sof = 1; pix_rgb = 24'hFFFFFF;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs low under reset even with a busy input
    checks++;
    if (out_valid !== 1'b0 || out_sol !== 1'b0 || out_sof !== 1'b0) begin
      errs++;
      $display("FAIL R1: reset markers actual %b%b%b expected 000", out_valid, out_sol, out_sof);
    end
    pix_valid = 0; pix_sol = 0; pix_sof = 0;
    rst_n = 1;
    cur_req = "R1";
    repeat (3) idle_tick();

    // palette
    cur_req = "R1 R5";
    write_reg(5'h10, 8'h11); write_reg(5'h11, 8'h22); write_reg(5'h12, 8'h33);
    write_reg(5'h14, 8'hC4); write_reg(5'h15, 8'h5D); write_reg(5'h16, 8'h6E);
    write_reg(5'h18, 8'h07); write_reg(5'h19, 8'hF8); write_reg(5'h1A, 8'h90);

    // R3: 258 bytes wrap the pointer, then rewind and overwrite two bytes
    cur_req = "R3";
    for (int k = 0; k < 258; k++) write_reg(A_BM_DATA, 8'(k * 37 + 11));
    write_reg(A_BM_REWIND, 8'h5A);
    write_reg(A_BM_DATA, 8'hE4);
    write_reg(A_BM_DATA, 8'h1B);

    // R2: disabled cursor passes everything, R10 with idle gaps
    set_cursor(10, 6, 0, 0, 0);
    cur_req = "R2 R10";
    run_frame(7, -1, 0);

    // R4, R5, R6 invert, R3 contents
    set_cursor(10, 6, 0, 0, 1);
    cur_req = "R3 R4 R5 R6 R10";
    run_frame(5, -1, 0);

    // R6 auxiliary, R7 and R8 with negative origin
    set_cursor(5, 2, 7, 3, 3);
    cur_req = "R6 R7 R8";
    run_frame(0, -1, 0);

    // R8 right and bottom clip, R9 mid-frame move stays hidden
    set_cursor(40, 30, 2, 1, 1);
    cur_req = "R8 R9";
    run_frame(9, 20, 20);

    // R9 the move shows up on the next frame
    cur_req = "R9 R7";
    run_frame(0, -1, 0);

    // R7 full hot spot, R9 colour written right before the frame
    set_cursor(31, 31, 31, 31, 1);
    write_reg(5'h14, 8'h3C);
    cur_req = "R7 R9 R5";
    run_frame(3, -1, 0);

    repeat (3) idle_tick();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule